// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static RAM for cache data. Each word is 18 bits wide and is split into two 9-bit byte lanes. Every input except the output enable is captured on the rising clock edge. A read returns its word through an output register one clock after the cycle that sampled it. A write goes into the array on the clock edge after it is sampled, with no separate write pulse.

An access sequence opens when either of two start strobes is sampled while the select input is high. That cycle loads the external address as the burst base. Each later cycle that has no strobe continues the burst. If `step` is high, an internal 2-bit counter moves to the next word in an interleaved order. If `step` is low, the same word is accessed again.

A small two-state machine tracks whether a burst is open:
- `ST_IDLE` to `ST_BURST` on a selected strobe (load).
- `ST_BURST` stays in `ST_BURST` on a load or on a continue cycle.
- `ST_BURST` to `ST_IDLE` when the controller strobe is sampled with select low (deselect).
- `ST_IDLE` stays in `ST_IDLE` otherwise.

The array holds 2**ADDR_W words. ADDR_W = 16 gives the full 65,536-word part. The default is smaller so that elaboration stays light.

Top module: `burst_sram`

## Requirements
- R1: A word written at an address is returned unchanged by a later read of that address. A write and a read of the same address in back-to-back cycles return the new data.
- R2: A read sampled at rising edge N drives `rdata` with `rdata_drive` high after edge N+1. A cycle with a write, or with no access, leaves `rdata_drive` low one edge later.
- R3: When `sel` is high and `start_host` or `start_ctrl` is sampled high, the access in that cycle uses `addr` as sampled, and the burst counter restarts at 0.
- R4: In a cycle with no strobe while a burst is open and `step` high, the counter advances by one modulo 4. The accessed address is the base with its two low bits XORed with the count, so a base with low bits 1 visits 1,0,3,2 and then 1 again. Bits above bit 1 never change within a burst.
- R5: In a cycle with no strobe while a burst is open and `step` low, the access repeats the previous address.
- R6: `wen_lo` writes bits 8:0 and `wen_hi` writes bits 17:9. A lane whose enable is low keeps its old contents.
- R7: `rdata_drive` follows `out_en` combinationally. It is low in the same cycle that `out_en` is low, with no clock edge needed.
- R8: A strobe sampled with `sel` low loads nothing and causes no access or write.
  - `start_ctrl` in that case closes the burst, so later `step` cycles access nothing.
  - `start_host` alone in that case leaves the open burst and its counter untouched.
- R9: A load by `start_host` is always a read, and the write enables are ignored in that cycle. If both strobes are high, `start_host` takes precedence. A load by `start_ctrl` honours the write enables.
- R10: After reset the block is in `ST_IDLE` with `rdata_drive` low. Reset is asynchronous and active low, and it clears any open burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Burst start address |
| wdata | input | 2*LANE_W | Write data |
| sel | input | 1 | Select, qualifies the start strobes |
| start_host | input | 1 | Processor-side start strobe (load is a read) |
| start_ctrl | input | 1 | Controller-side start strobe |
| step | input | 1 | Advance the burst counter |
| wen_lo | input | 1 | Write enable for bits 8:0 |
| wen_hi | input | 1 | Write enable for bits 17:9 |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | 2*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when `rdata` is driven (stands in for high impedance) |

## Verification
Assertions check the following on every cycle:
- A selected load takes the external address (R3).
- A step keeps the upper address bits while changing the low two (R4).
- A stall repeats the address (R5).
- A deselect cycle produces no access (R8).
- A host-strobe load never writes (R9).
- Read valid appears only one edge after a read access (R2).
- `out_en` low forces the drive flag low (R7).

Only the bench scenarios can show:
- The interleaved sequence from each of the four starting offsets, with wrap-around.
- Byte-lane merging in stored data.
- That writes attempted while the block is idle, or during a deselect, do not reach the array.
- That a burst resumes correctly after an ignored host strobe.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    // Width of the in-burst word counter (four words per burst).
    localparam int BURST_BITS = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;
endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start_host,
    input  logic              start_ctrl,
    input  logic              step,
    input  logic              wen_lo,
    input  logic              wen_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              acc_vld_q,
    output logic [ADDR_W-1:0] acc_addr_q,
    output logic [DATA_W-1:0] acc_din_q,
    output logic              we_lo_q,
    output logic              we_hi_q
);
    localparam int CB = BURST_BITS;

    burst_state_e state_q, state_d;
    logic [CB-1:0]     cnt_q, cnt_d;
    logic [ADDR_W-1:0] base_q, base_d, acc_addr_d;
    logic              acc_d, wl_d, wh_d;
    logic              strobe, load, desel, cont;

    assign strobe = start_host | start_ctrl;
    assign load   = sel & strobe;
    assign desel  = ~sel & start_ctrl;
    assign cont   = ~strobe & (state_q == ST_BURST);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load)  state_d = ST_BURST;
            ST_BURST: if (desel) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Per-cycle access decision
    always_comb begin
        cnt_d  = cnt_q;
        base_d = base_q;
        acc_d  = 1'b0;
        wl_d   = 1'b0;
        wh_d   = 1'b0;
        if (load) begin
            base_d = addr;
            cnt_d  = '0;
            acc_d  = 1'b1;
            wl_d   = wen_lo & ~start_host;
            wh_d   = wen_hi & ~start_host;
        end else if (cont) begin
            if (step) cnt_d = cnt_q + 1'b1;
            acc_d = 1'b1;
            wl_d  = wen_lo;
            wh_d  = wen_hi;
        end
        acc_addr_d = {base_d[ADDR_W-1:CB], base_d[CB-1:0] ^ cnt_d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            base_q     <= '0;
            acc_vld_q  <= 1'b0;
            we_lo_q    <= 1'b0;
            we_hi_q    <= 1'b0;
            acc_addr_q <= '0;
            acc_din_q  <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            base_q     <= base_d;
            acc_vld_q  <= acc_d;
            we_lo_q    <= wl_d;
            we_hi_q    <= wh_d;
            acc_addr_q <= acc_addr_d;
            acc_din_q  <= wdata;
        end
    end

    // R3: a selected strobe accesses the sampled address
    p_load_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_vld_q && acc_addr_q == $past(addr)));

    // R4: a step stays within the aligned group of four and moves the low bits
    p_step_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && step && acc_vld_q) |=>
            (acc_addr_q[ADDR_W-1:CB] == $past(acc_addr_q[ADDR_W-1:CB]) &&
             acc_addr_q[CB-1:0] != $past(acc_addr_q[CB-1:0])));

    // R5: a stall repeats the address
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !step && acc_vld_q) |=> (acc_vld_q && $stable(acc_addr_q)));

    // R8: a strobe without select makes no access
    p_desel_noacc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && strobe) |=> !acc_vld_q);

    // R9: a host-strobe load is a read
    p_host_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && start_host) |=> (acc_vld_q && !we_lo_q && !we_hi_q));
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_vld,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] acc_din,
    input  logic [LANES-1:0]        we,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_vld_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic rd_now;
    assign rd_now = acc_vld & ~|we;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (acc_vld && we[g]) mem[acc_addr] <= acc_din[g*LANE_W +: LANE_W];
            if (rd_now) lane_q <= mem[acc_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld_q <= 1'b0;
        else        rd_vld_q <= rd_now;
    end

    // R2: valid read data only follows a read access one edge earlier
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_q |-> $past(acc_vld && we == '0));
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   wdata,
    input  logic                  sel,
    input  logic                  start_host,
    input  logic                  start_ctrl,
    input  logic                  step,
    input  logic                  wen_lo,
    input  logic                  wen_hi,
    input  logic                  out_en,
    output logic [2*LANE_W-1:0]   rdata,
    output logic                  rdata_drive
);
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;

    logic              acc_vld, we_lo, we_hi, rd_vld;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_din;

    burst_addr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .start_host (start_host),
        .start_ctrl (start_ctrl),
        .step       (step),
        .wen_lo     (wen_lo),
        .wen_hi     (wen_hi),
        .addr       (addr),
        .wdata      (wdata),
        .acc_vld_q  (acc_vld),
        .acc_addr_q (acc_addr),
        .acc_din_q  (acc_din),
        .we_lo_q    (we_lo),
        .we_hi_q    (we_hi)
    );

    burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_vld  (acc_vld),
        .acc_addr (acc_addr),
        .acc_din  (acc_din),
        .we       ({we_hi, we_lo}),
        .rd_data  (rdata),
        .rd_vld_q (rd_vld)
    );

    assign rdata_drive = out_en & rd_vld;

    // R7: output enable low means nothing is driven
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !rdata_drive);
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
    localparam int AW   = 10;
    localparam int DW   = 18;
    localparam int ROWS = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic sel = 1'b0, start_host = 1'b0, start_ctrl = 1'b0, step = 1'b0;
    logic wen_lo = 1'b0, wen_hi = 1'b0, out_en = 1'b1;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANE_W(9)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .sel(sel),
        .start_host(start_host), .start_ctrl(start_ctrl), .step(step),
        .wen_lo(wen_lo), .wen_hi(wen_hi), .out_en(out_en),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    // Row: {host, ctrl, sel, step, wl, wh, addr, wdata, expect_access, expect_addr}
    function automatic logic [44:0] mk(input logic ap, ac, e, a, l, h,
                                       input logic [9:0] ad, input logic [17:0] d,
                                       input logic acc, input logic [9:0] ea);
        return {ap, ac, e, a, l, h, ad, d, acc, ea};
    endfunction

    localparam logic [44:0] VEC [ROWS] = '{
        mk(0,1,1,0,1,1,10'h041,18'h10001,1,10'h041),
        mk(0,0,1,1,1,1,10'h000,18'h20002,1,10'h040),
        mk(0,0,1,1,1,1,10'h000,18'h30003,1,10'h043),
        mk(0,0,1,1,1,1,10'h000,18'h04004,1,10'h042),
        mk(0,0,1,1,1,1,10'h000,18'h15005,1,10'h041),
        mk(1,0,1,0,1,0,10'h042,18'h3FFFF,1,10'h042),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h043),
        mk(0,0,1,0,0,0,10'h000,18'h00000,1,10'h043),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h040),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h041),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h042),
        mk(0,1,1,0,1,1,10'h080,18'h2B0B0,1,10'h080),
        mk(0,0,1,1,1,1,10'h000,18'h0B1B1,1,10'h081),
        mk(0,0,1,1,1,1,10'h000,18'h1B2B2,1,10'h082),
        mk(0,0,1,1,1,1,10'h000,18'h3B3B3,1,10'h083),
        mk(0,0,1,1,1,0,10'h000,18'h3FFFF,1,10'h080),
        mk(0,0,1,0,0,1,10'h000,18'h00000,1,10'h080),
        mk(1,0,1,0,0,0,10'h083,18'h00000,1,10'h083),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h082),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h081),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h080),
        mk(0,1,1,0,0,0,10'h081,18'h00000,1,10'h081),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h080),
        mk(0,1,0,0,1,1,10'h080,18'h15555,0,10'h000),
        mk(0,0,1,1,1,1,10'h000,18'h2AAAA,0,10'h000),
        mk(0,1,1,0,0,0,10'h080,18'h00000,1,10'h080),
        mk(1,0,0,0,1,1,10'h000,18'h3C3C3,0,10'h000),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h081),
        mk(0,0,1,0,0,0,10'h000,18'h00000,1,10'h081),
        mk(1,0,1,0,0,0,10'h040,18'h00000,1,10'h040),
        mk(0,0,1,1,0,0,10'h000,18'h00000,1,10'h041)
    };

    logic [DW-1:0] refm [1 << AW];
    bit            edrv [ROWS];
    logic [DW-1:0] edat [ROWS];
    string         etag [ROWS];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_host = 1'b0; start_ctrl = 1'b0; step = 1'b0;
        wen_lo = 1'b0; wen_hi = 1'b0; sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: idle after reset, nothing driven
        chk("R10 reset drive", {31'd0, rdata_drive}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle drive", {31'd0, rdata_drive}, 32'd0);

        // Table walk: row i results are visible two falling edges later
        for (int i = 0; i < ROWS + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk({"R2 drive ", etag[i-2]}, {31'd0, rdata_drive}, {31'd0, edrv[i-2]});
                if (edrv[i-2]) chk({"R1 data ", etag[i-2]}, {14'd0, rdata}, {14'd0, edat[i-2]});
            end
            if (i < ROWS) begin
                logic [44:0] v;
                logic        ap, ac, e, a, l, h, acc, wr;
                logic [9:0]  ea;
                v  = VEC[i];
                ap = v[44]; ac = v[43]; e = v[42]; a = v[41]; l = v[40]; h = v[39];
                acc = v[10]; ea = v[9:0];
                start_host = ap; start_ctrl = ac; sel = e; step = a;
                wen_lo = l; wen_hi = h; addr = v[38:29]; wdata = v[28:11];
                // R9: host load is a read; R6: lanes written independently
                wr = acc && (l || h) && !(ap && e);
                if (wr) begin
                    if (l) refm[ea][8:0]  = v[19:11];
                    if (h) refm[ea][17:9] = v[28:20];
                end
                edrv[i] = acc && !wr;
                edat[i] = refm[ea];
                if (!acc)                     etag[i] = "R8 row";
                else if (ap && e && (l || h)) etag[i] = "R9 row";
                else if (ap || ac)            etag[i] = "R3 row";
                else if (a)                   etag[i] = "R4 row";
                else                          etag[i] = "R5 row";
                if (ea == 10'h080 && !wr) etag[i] = {etag[i], " R6 lanes"};
            end else begin
                idle_inputs();
            end
        end

        // R7: output enable acts without a clock edge
        @(negedge clk);
        sel = 1'b1; start_host = 1'b1; addr = 10'h043;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk("R7 drive with enable", {31'd0, rdata_drive}, 32'd1);
        chk("R1 data 0x043", {14'd0, rdata}, {14'd0, 18'h30003});
        #1 out_en = 1'b0;
        #1 chk("R7 enable low", {31'd0, rdata_drive}, 32'd0);
        #1 out_en = 1'b1;
        #1 chk("R7 enable back", {31'd0, rdata_drive}, 32'd1);

        // R10: reset mid-burst closes it
        @(negedge clk);
        sel = 1'b1; start_ctrl = 1'b1; addr = 10'h080;
        @(negedge clk);
        idle_inputs();
        step = 1'b1;
        #1 rst_n = 1'b0;
        #1 chk("R10 async reset", {31'd0, rdata_drive}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 no burst after reset", {31'd0, rdata_drive}, 32'd0);
        end
        idle_inputs();
        finish_run();
    end
endmodule